// File: doc/BRIEF.md
# Flash Program/Erase Lock Gate

This block decides, for one target address at a time, whether a program or erase request to a small parallel flash array must be refused. The array has one boot block at the top of the address map and several main sectors below it. Two board-level pins take part: an active-low boot-lock pin and an active-low write-protect pin. A software boot-lock flag held elsewhere in the device also takes part.

The hardware boot lock always overrides the software flag. The write-protect pin acts only on the main sectors.

The block also supplies the lockout-detection byte. Host firmware reads this byte in identification mode to learn the pin levels. The byte reports each pin inverted, so a 1 means that lock is active. Both pin inputs are synchronised before use. The two outputs are registered.

Top module: `flash_guard`

## Requirements
- R1: When the ID-mode input is 1 and the read address equals STATUS_ADDR (default 0x7FFF2), the ID data output one cycle later has bit 2 equal to the inverse of the synchronised boot-lock pin and bit 3 equal to the inverse of the synchronised write-protect pin.
- R2: Every other bit of that status byte reads 0. Any read made with the ID-mode input at 0, or at any other read address, returns 0x00.
- R3: With the boot-lock pin low, a target inside the boot block is inhibited (inhibit output 1) whatever the software lock is.
- R4: With the boot-lock pin high, a target inside the boot block is inhibited exactly when the software lock is 1.
- R5: With the write-protect pin low, every target outside the boot block is inhibited.
- R6: With the write-protect pin high, targets outside the boot block are allowed (inhibit 0). The write-protect pin has no effect on boot-block targets.
- R7: The boot-lock pin and the software lock have no effect on targets outside the boot block.
- R8: The boot block is the top 64 KB of the map: every address whose upper ADDR_W-16 bits are all ones (0x70000 to 0x7FFFF by default).
- R9: Each pin passes through a two-flop synchroniser, so a pin change reaches the outputs on the third rising edge after it. Changes on the address, the software lock or the ID-mode input reach the outputs on the next rising edge.
- R10: While reset is held, and before the first edge after it, inhibit reads 1 and the ID data reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_lock_n_i | input | 1 | Boot-lock pin, active low, asynchronous |
| wp_n_i | input | 1 | Write-protect pin, active low, asynchronous |
| sw_boot_lock_i | input | 1 | Software boot-lock flag |
| tgt_addr_i | input | ADDR_W | Target address of the program/erase request |
| id_mode_i | input | 1 | Device is in identification mode |
| rd_addr_i | input | ADDR_W | Read address during identification mode |
| inhibit_o | output | 1 | 1 = program/erase at the target is refused |
| id_data_o | output | 8 | Identification read data (lockout byte) |

## Verification
The assertions assume that the pins are the only asynchronous inputs. They also assume that the address, software-lock and ID-mode inputs are steady around each rising edge, because the properties compare registered outputs with the previous cycle's decoded inputs.

The bench changes every input at the falling edge. After a pin change it waits at least three rising edges before it samples, except in the latency check, which samples on purpose at the second and third edges.

The bench sweeps all eight combinations of the pin levels and the software lock. Within each combination it steps six addresses on both sides of the boot boundary and makes the ID reads.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    localparam int BOOT_SPAN_W  = 16;  // boot block size = 2**BOOT_SPAN_W bytes
    localparam int STAT_BOOT_B  = 2;   // status byte: inverted boot-lock pin
    localparam int STAT_WP_B    = 3;   // status byte: inverted write-protect pin

    typedef struct packed {
        logic       inhibit;
        logic [7:0] id_data;
    } guard_out_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = pin_i;
        s2_d = s1_q;
    end

    // Reset to 0: pins read as asserted (locked) until the sampled level arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign pin_o = s2_q;

    assert_second_stage_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q == s2_q) |=> $stable(s2_q));
endmodule

// File: rtl/boot_region_dec.sv
module boot_region_dec #(
    parameter int ADDR_W = 19,
    parameter int SPAN_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_boot_o
);
    localparam int TOP_W = ADDR_W - SPAN_W;

    // R8: the boot block is selected when all upper address bits are ones.
    always_comb begin
        is_boot_o = &addr_i[ADDR_W-1 -: TOP_W];
    end
endmodule

// File: rtl/lock_status_byte.sv
module lock_status_byte #(
    parameter int                ADDR_W      = 19,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 19'h7FFF2
) (
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              boot_pin_s_i,
    input  logic              wp_pin_s_i,
    output logic [7:0]        byte_o
);
    import flash_guard_pkg::*;

    always_comb begin
        byte_o = 8'h00;
        if (id_mode_i && (rd_addr_i == STATUS_ADDR)) begin
            byte_o[STAT_BOOT_B] = ~boot_pin_s_i;
            byte_o[STAT_WP_B]   = ~wp_pin_s_i;
        end
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int                ADDR_W      = 19,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 19'h7FFF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_lock_n_i,
    input  logic              wp_n_i,
    input  logic              sw_boot_lock_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              inhibit_o,
    output logic [7:0]        id_data_o
);
    import flash_guard_pkg::*;

    logic [1:0] pins_s;
    logic       boot_s, wp_s, tgt_boot;
    logic [7:0] stat_byte;
    guard_out_t out_d, out_q;

    pin_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({wp_n_i, boot_lock_n_i}),
        .pin_o (pins_s)
    );
    assign boot_s = pins_s[0];
    assign wp_s   = pins_s[1];

    boot_region_dec #(.ADDR_W(ADDR_W), .SPAN_W(BOOT_SPAN_W)) u_dec (
        .addr_i    (tgt_addr_i),
        .is_boot_o (tgt_boot)
    );

    lock_status_byte #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_stat (
        .id_mode_i    (id_mode_i),
        .rd_addr_i    (rd_addr_i),
        .boot_pin_s_i (boot_s),
        .wp_pin_s_i   (wp_s),
        .byte_o       (stat_byte)
    );

    always_comb begin
        out_d = out_q;
        if (tgt_boot) begin
            // R3/R4: the hardware lock overrides; otherwise the software flag decides.
            out_d.inhibit = ~boot_s | sw_boot_lock_i;
        end else begin
            // R5/R6/R7: only the write-protect pin acts on the main sectors.
            out_d.inhibit = ~wp_s;
        end
        out_d.id_data = stat_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{inhibit: 1'b1, id_data: 8'h00};
        end else begin
            out_q <= out_d;
        end
    end

    assign inhibit_o = out_q.inhibit;
    assign id_data_o = out_q.id_data;

    assert_boot_hw_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_boot && !boot_s) |=> inhibit_o);
    assert_boot_sw_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_boot && boot_s) |=> (inhibit_o == $past(sw_boot_lock_i)));
    assert_main_wp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_boot && !wp_s) |=> inhibit_o);
    assert_main_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_boot && wp_s) |=> !inhibit_o);
    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode_i |=> (id_data_o == 8'h00));
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
    localparam int ADDR_W = 19;
    localparam logic [ADDR_W-1:0] STAT = 19'h7FFF2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_n = 1'b1, wp_n = 1'b1, sw = 1'b0, idm = 1'b0;
    logic [ADDR_W-1:0] tgt = '0, rda = '0;
    logic inh;
    logic [7:0] idd;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    flash_guard #(.ADDR_W(ADDR_W), .STATUS_ADDR(STAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_lock_n_i(boot_n), .wp_n_i(wp_n),
        .sw_boot_lock_i(sw), .tgt_addr_i(tgt), .id_mode_i(idm),
        .rd_addr_i(rda), .inhibit_o(inh), .id_data_o(idd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        step(50000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] addrs [6];
        addrs = '{19'h00000, 19'h12345, 19'h6FFFF, 19'h70000, 19'h7ABCD, 19'h7FFFF};

        // R10: reset values
        step(2);
        chk("R10 inhibit", {7'd0, inh}, 8'h01);
        chk("R10 id_data", idd, 8'h00);
        rst_n = 1'b1;
        step(4);

        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 2; s++) begin
                    boot_n = b[0]; wp_n = w[0]; sw = s[0];
                    step(4);
                    foreach (addrs[i]) begin
                        logic isb, exp;
                        tgt = addrs[i];
                        step(1);
                        isb = (addrs[i] >= 19'h70000);  // R8
                        if (isb) begin
                            exp = (b == 0) ? 1'b1 : s[0];
                            chk((b == 0) ? "R3 R8 boot hw lock" : "R4 R6 R8 boot sw lock",
                                {7'd0, inh}, {7'd0, exp});
                        end else begin
                            exp = (w == 0);
                            chk((w == 0) ? "R5 R7 R8 main wp" : "R6 R7 R8 main open",
                                {7'd0, inh}, {7'd0, exp});
                        end
                    end
                    idm = 1'b1; rda = STAT;
                    step(1);
                    chk("R1 status byte", idd, {4'd0, ~w[0], ~b[0], 2'b00});
                    rda = STAT ^ 19'h1;
                    step(1);
                    chk("R2 other id addr", idd, 8'h00);
                    idm = 1'b0; rda = STAT;
                    step(1);
                    chk("R2 not id mode", idd, 8'h00);
                end
            end
        end

        // R9: pin latency of three edges
        boot_n = 1'b1; wp_n = 1'b1; sw = 1'b0; tgt = 19'h7FFFF;
        idm = 1'b1; rda = STAT;
        step(5);
        chk("R9 settled", {7'd0, inh}, 8'h00);
        boot_n = 1'b0; wp_n = 1'b0;
        step(2);
        chk("R9 two edges inhibit", {7'd0, inh}, 8'h00);
        chk("R9 two edges status", idd, 8'h00);
        step(1);
        chk("R9 three edges inhibit", {7'd0, inh}, 8'h01);
        chk("R9 three edges status", idd, 8'h0C);
        // R9: software lock one-edge latency
        boot_n = 1'b1;
        step(4);
        sw = 1'b1;
        step(1);
        chk("R9 sw latency", {7'd0, inh}, 8'h01);

        finish_run();
    end
endmodule